// File: doc/BRIEF.md
# Second-Order Masked Nonlinear Shift Register

This block is a four-position nonlinear feedback shift register whose contents never exist in plain form. Each position holds one secret bit split into XOR shares. The three upper positions each carry five shares. The bottom position carries ten shares, produced by a non-complete sharing of the feedback function. Every ten-share term depends on shares of at most two input share indices, so it resists second-order probing even when the logic glitches.

On a step, the feedback value `pos3 AND pos2 XOR pos1` is computed share-wise from the registered upper positions. It is then re-masked with a fresh random sharing of zero and written into position 0. In the same step, the registered ten shares already held in position 0 are folded down to five and move into position 1, and positions 1 and 2 move up one place. The fold is taken only from registered shares, so no combinational cone ever sees every share of a value.

A load strobe writes an initial five-share state. The random vector must be fresh on every step. Key injection and recombination of shares into plain bits are the job of the surrounding logic.

Top module: `mnlfsr_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every share of every position becomes 0 at that edge.
- R2: When `load_i` is high at a rising edge, positions 1 to 3 take `ld_pos1_i` to `ld_pos3_i`. Position 0 takes `ld_pos0_i` in its share bits 0 to 4 and zeros in bits 5 to 9. This happens whatever `step_i` is.
- R3: With `load_i` and `step_i` both low, every share of every position keeps its value.
- R4: After a step, the XOR of the ten shares of position 0 equals (x3 AND x2) XOR x1. Here xk is the XOR of the shares of position k before the step.
- R5: With `rnd_i` zero, the new position-0 shares follow a fixed layout. Share index k is bit k-1, a = pos3, b = pos2, c = pos1. The shares are: d1=c2^a2b2^a1b2^a2b1, d2=c3^a3b3^a1b3^a3b1, d3=c4^a4b4^a1b4^a4b1, d4=c1^a1b1^a1b5^a5b1, d5=a2b3^a3b2, d6=a2b4^a4b2, d7=c5^a5b5^a2b5^a5b2, d8=a3b4^a4b3, d9=a3b5^a5b3, d10=a4b5^a5b4.
- R6: Refresh: share dk for k=1..9 is additionally XORed with `rnd_i` bit k-1. Share d10 is XORed with the XOR of all nine `rnd_i` bits.
- R7: On a step, bits 0 to 3 of the new position 1 are bits 0 to 3 of the old position 0. Bit 4 of the new position 1 is the XOR of bits 4 to 9 of the old position 0.
- R8: On a step, position 2 takes the old position 1 and position 3 takes the old position 2, share for share.
- R9: The plain values (XOR of shares) of all four positions follow an unmasked 4-bit register that shifts and has feedback (b3 AND b2) XOR b1 into bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe, has priority over step |
| step_i | input | 1 | Advance the register by one position |
| ld_pos0_i | input | 5 | Initial shares for position 0 |
| ld_pos1_i | input | 5 | Initial shares for position 1 |
| ld_pos2_i | input | 5 | Initial shares for position 2 |
| ld_pos3_i | input | 5 | Initial shares for position 3 |
| rnd_i | input | 9 | Fresh randomness for the zero-sharing refresh |
| pos0_o | output | 10 | Shares of position 0 |
| pos1_o | output | 5 | Shares of position 1 |
| pos2_o | output | 5 | Shares of position 2 |
| pos3_o | output | 5 | Shares of position 3 |

## Verification
All state is visible at the ports, so a wrong share shows up on the clock edge that produced it, and the bench compares every share in every cycle. A wrong cross term or mask bit can leave the plain value intact. For that reason the exact share layout is compared, first with zero randomness and then with random masks. The plain values are also tracked against an unmasked register, because a fold or feedback error that stays hidden inside the shares will corrupt the recombined sequence within one to four steps as the bit travels upward.

// File: rtl/mnlfsr_pkg.sv
package mnlfsr_pkg;

    localparam int NS = 5;          // shares per upper position
    localparam int NF = 10;         // shares of the feedback position
    localparam int RW = NF - 1;     // random bits per refresh
    localparam int NPOS = 4;

    typedef struct packed {
        logic [NS-1:0] p3;
        logic [NS-1:0] p2;
        logic [NS-1:0] p1;
        logic [NF-1:0] p0;
    } mstate_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic load, input logic step);
        if (load) return OP_LOAD;
        if (step) return OP_STEP;
        return OP_HOLD;
    endfunction

    // product of share i of x and share j of y (1-based indices)
    function automatic logic xm(input logic [NS-1:0] x, input logic [NS-1:0] y,
                                input int i, input int j);
        return x[i-1] & y[j-1];
    endfunction

endpackage

// File: rtl/mnlfsr_fb_share.sv
module mnlfsr_fb_share
    import mnlfsr_pkg::*;
(
    input  logic [NS-1:0] a_i,
    input  logic [NS-1:0] b_i,
    input  logic [NS-1:0] c_i,
    output logic [NF-1:0] d_o
);
    // Each output share uses at most two distinct share indices.
    always_comb begin
        d_o[0] = c_i[1] ^ xm(a_i, b_i, 2, 2) ^ xm(a_i, b_i, 1, 2) ^ xm(a_i, b_i, 2, 1);
        d_o[1] = c_i[2] ^ xm(a_i, b_i, 3, 3) ^ xm(a_i, b_i, 1, 3) ^ xm(a_i, b_i, 3, 1);
        d_o[2] = c_i[3] ^ xm(a_i, b_i, 4, 4) ^ xm(a_i, b_i, 1, 4) ^ xm(a_i, b_i, 4, 1);
        d_o[3] = c_i[0] ^ xm(a_i, b_i, 1, 1) ^ xm(a_i, b_i, 1, 5) ^ xm(a_i, b_i, 5, 1);
        d_o[4] = xm(a_i, b_i, 2, 3) ^ xm(a_i, b_i, 3, 2);
        d_o[5] = xm(a_i, b_i, 2, 4) ^ xm(a_i, b_i, 4, 2);
        d_o[6] = c_i[4] ^ xm(a_i, b_i, 5, 5) ^ xm(a_i, b_i, 2, 5) ^ xm(a_i, b_i, 5, 2);
        d_o[7] = xm(a_i, b_i, 3, 4) ^ xm(a_i, b_i, 4, 3);
        d_o[8] = xm(a_i, b_i, 3, 5) ^ xm(a_i, b_i, 5, 3);
        d_o[9] = xm(a_i, b_i, 4, 5) ^ xm(a_i, b_i, 5, 4);
    end
endmodule

// File: rtl/mnlfsr_zero_refresh.sv
module mnlfsr_zero_refresh
    import mnlfsr_pkg::*;
#(
    parameter int W = NF
) (
    input  logic [W-1:0] d_i,
    input  logic [W-2:0] rnd_i,
    output logic [W-1:0] d_o
);
    logic [W-1:0] mask;

    for (genvar k = 0; k < W - 1; k++) begin : g_mask
        assign mask[k] = rnd_i[k];
    end
    assign mask[W-1] = ^rnd_i;

    assign d_o = d_i ^ mask;
endmodule

// File: rtl/mnlfsr_compress.sv
module mnlfsr_compress
    import mnlfsr_pkg::*;
#(
    parameter int NIN  = NF,
    parameter int NOUT = NS
) (
    input  logic [NIN-1:0]  wide_i,
    output logic [NOUT-1:0] narrow_o
);
    localparam int NPASS = NOUT - 1;

    for (genvar k = 0; k < NPASS; k++) begin : g_pass
        assign narrow_o[k] = wide_i[k];
    end
    assign narrow_o[NOUT-1] = ^wide_i[NIN-1:NPASS];
endmodule

// File: rtl/mnlfsr_top.sv
module mnlfsr_top
    import mnlfsr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [NS-1:0] ld_pos0_i,
    input  logic [NS-1:0] ld_pos1_i,
    input  logic [NS-1:0] ld_pos2_i,
    input  logic [NS-1:0] ld_pos3_i,
    input  logic [RW-1:0] rnd_i,
    output logic [NF-1:0] pos0_o,
    output logic [NS-1:0] pos1_o,
    output logic [NS-1:0] pos2_o,
    output logic [NS-1:0] pos3_o
);
    mstate_t       st_q, st_d;
    op_e           op;
    logic [NF-1:0] fb_raw, fb_fresh;
    logic [NS-1:0] folded;

    mnlfsr_fb_share u_fb (
        .a_i (st_q.p3),
        .b_i (st_q.p2),
        .c_i (st_q.p1),
        .d_o (fb_raw)
    );

    mnlfsr_zero_refresh #(.W(NF)) u_rf (
        .d_i   (fb_raw),
        .rnd_i (rnd_i),
        .d_o   (fb_fresh)
    );

    // fold only from the registered ten shares
    mnlfsr_compress #(.NIN(NF), .NOUT(NS)) u_cp (
        .wide_i   (st_q.p0),
        .narrow_o (folded)
    );

    assign op = decode_op(load_i, step_i);

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.p0 = {{(NF-NS){1'b0}}, ld_pos0_i};
                st_d.p1 = ld_pos1_i;
                st_d.p2 = ld_pos2_i;
                st_d.p3 = ld_pos3_i;
            end
            OP_STEP: begin
                st_d.p0 = fb_fresh;
                st_d.p1 = folded;
                st_d.p2 = st_q.p1;
                st_d.p3 = st_q.p2;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pos0_o = st_q.p0;
    assign pos1_o = st_q.p1;
    assign pos2_o = st_q.p2;
    assign pos3_o = st_q.p3;

    // ---------------- assertions ----------------
    p_reset_r1: assert property (@(posedge clk) rst |=> (st_q == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (pos1_o == $past(ld_pos1_i)) && (pos3_o == $past(ld_pos3_i))
                   && (pos0_o[NS-1:0] == $past(ld_pos0_i)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i) |=> $stable(st_q));

    p_fb_value_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && step_i) |=> (^pos0_o) == (($past(^pos3_o) & $past(^pos2_o)) ^ $past(^pos1_o)));

    p_fold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && step_i) |=> ((^pos1_o) == $past(^pos0_o))
                                && (pos1_o[NS-2:0] == $past(pos0_o[NS-2:0])));

    p_shift_r8: assert property (@(posedge clk) disable iff (rst)
        (!load_i && step_i) |=> (pos2_o == $past(pos1_o)) && (pos3_o == $past(pos2_o)));

endmodule

// File: tb/mnlfsr_top_tb.sv
module mnlfsr_top_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       load_i, step_i;
    logic [4:0] ld0, ld1, ld2, ld3;
    logic [8:0] rnd;
    logic [9:0] pos0_o;
    logic [4:0] pos1_o, pos2_o, pos3_o;

    int total = 0;
    int bad = 0;

    // behavioural expectation
    logic [9:0] e0;
    logic [4:0] e1, e2, e3;
    logic [3:0] plain;

    always #4 clk = ~clk;

    mnlfsr_top u_dut (
        .clk(clk), .rst(rst), .load_i(load_i), .step_i(step_i),
        .ld_pos0_i(ld0), .ld_pos1_i(ld1), .ld_pos2_i(ld2), .ld_pos3_i(ld3),
        .rnd_i(rnd), .pos0_o(pos0_o), .pos1_o(pos1_o), .pos2_o(pos2_o), .pos3_o(pos3_o)
    );

    function automatic logic [9:0] expect_fb(input logic [4:0] a, input logic [4:0] b,
                                             input logic [4:0] c, input logic [8:0] r);
        logic [9:0] d;
        logic a1, a2, a3, a4, a5, b1, b2, b3, b4, b5;
        {a5, a4, a3, a2, a1} = a;
        {b5, b4, b3, b2, b1} = b;
        d[0] = c[1] ^ (a2&b2) ^ (a1&b2) ^ (a2&b1);
        d[1] = c[2] ^ (a3&b3) ^ (a1&b3) ^ (a3&b1);
        d[2] = c[3] ^ (a4&b4) ^ (a1&b4) ^ (a4&b1);
        d[3] = c[0] ^ (a1&b1) ^ (a1&b5) ^ (a5&b1);
        d[4] = (a2&b3) ^ (a3&b2);
        d[5] = (a2&b4) ^ (a4&b2);
        d[6] = c[4] ^ (a5&b5) ^ (a2&b5) ^ (a5&b2);
        d[7] = (a3&b4) ^ (a4&b3);
        d[8] = (a3&b5) ^ (a5&b3);
        d[9] = (a4&b5) ^ (a5&b4);
        return d ^ {^r, r};
    endfunction

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string t0, input string t1, input string t23);
        check(t0, pos0_o, e0);
        check(t1, {5'b0, pos1_o}, {5'b0, e1});
        check(t23, {5'b0, pos2_o}, {5'b0, e2});
        check(t23, {5'b0, pos3_o}, {5'b0, e3});
        // R9: unshared view against the plain reference register
        check("R9", {6'b0, ^pos3_o, ^pos2_o, ^pos1_o, ^pos0_o}, {6'b0, plain});
    endtask

    task automatic cycle(input logic ld, input logic st, input logic [8:0] r);
        logic [9:0] n0;
        logic [4:0] n1;
        @(negedge clk);
        load_i = ld; step_i = st; rnd = r;
        ld0 = 5'($urandom); ld1 = 5'($urandom); ld2 = 5'($urandom); ld3 = 5'($urandom);
        @(posedge clk);
        if (ld) begin
            e0 = {5'b0, ld0}; e1 = ld1; e2 = ld2; e3 = ld3;
            plain = {^ld3, ^ld2, ^ld1, ^ld0};
        end else if (st) begin
            n0 = expect_fb(e3, e2, e1, r);
            n1 = {^e0[9:4], e0[3:0]};
            e3 = e2; e2 = e1; e1 = n1; e0 = n0;
            plain = {plain[2:0], (plain[3] & plain[2]) ^ plain[1]};
        end
        #2;
        if (ld)      compare_all("R2", "R2", "R2");
        else if (st) begin
            compare_all((r == 9'd0) ? "R5" : "R6", "R7", "R8");
            check("R4", {9'b0, ^pos0_o}, {9'b0, plain[0]});
        end
        else         compare_all("R3", "R3", "R3");
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; load_i = 1'b0; step_i = 1'b0; rnd = '0;
        ld0 = '0; ld1 = '0; ld2 = '0; ld3 = '0;
        e0 = '0; e1 = '0; e2 = '0; e3 = '0; plain = '0;
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1", "R1", "R1");
        @(negedge clk);
        rst = 1'b0;

        // load, then hold
        cycle(1'b1, 1'b0, 9'd0);
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, 9'h1ff);
        // steps with zero randomness: exact share layout
        for (int k = 0; k < 12; k++) cycle(1'b0, 1'b1, 9'd0);
        // a reload with step also high: load wins
        cycle(1'b1, 1'b1, 9'h0aa);
        // single-bit masks, one per refresh bit
        for (int k = 0; k < 9; k++) cycle(1'b0, 1'b1, 9'(1 << k));
        // random masks, holds and reloads mixed in
        for (int k = 0; k < 300; k++) begin
            int sel = $urandom_range(0, 19);
            cycle(sel == 0, sel > 3, 9'($urandom));
        end
        // reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        e0 = '0; e1 = '0; e2 = '0; e3 = '0; plain = '0;
        compare_all("R1", "R1", "R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule